// File: doc/BRIEF.md
# Timer Pin I/O and Edge Interrupt Unit

This unit owns the one external pin attached to a general-purpose timer channel. Software programs a single mode word that picks what the pin does: it can be left unused, used for input capture, reserved for output compare or PWM, or run as a plain GPIO. In GPIO mode the pin floats as an input or is driven low or high. An open-drain option lets a high level release the pin instead of driving it.

In input capture mode the pin is resynchronised into the clock domain and watched for rising edges, falling edges or both. A selected edge sets a sticky capture flag. The flag can raise an interrupt line when the interrupt gate bit is set, and software clears it by writing ones. The synchronised pin level can always be read from the status word. The compare and PWM waveform generators sit outside this unit. In those modes the pin is left undriven.

The register port is a single-cycle write strobe plus a combinational read mux. Address 0 selects the mode word and address 1 selects the status word.

Top module: `tpio_unit`

## Requirements
- R1: After synchronous reset the mode word reads 0, the status word reads 0, `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: The mode word (address 0) keeps function bits 2:0, drive bits 5:4, interrupt gate bit 8, open-drain bit 9 and edge bits 17:16. All other bits read back as 0, so writing all ones reads back 0x00030337.
- R3: With function 4 (GPIO), drive 10 gives `pin_oe`=1 and `pin_out`=0, and drive 11 gives `pin_oe`=1 and `pin_out`=1. Drive 00 or 01 gives `pin_oe`=0.
- R4: With open-drain (bit 9) set in GPIO mode, drive 11 gives `pin_oe`=0 and drive 10 gives `pin_oe`=1 with `pin_out`=0.
- R5: In every function other than 4, `pin_oe` and `pin_out` are 0 whatever the drive bits hold. This includes input capture (1) with drive 11.
- R6: Status bit 8 (address 1) shows the pin level through a two-flop synchroniser. A change applied before a clock edge is visible after the second rising edge.
- R7: In input capture with edge field 01, a rising pin edge sets the capture flag (status bit 0) after the third rising clock edge, and a falling edge does not set it.
- R8: With edge field 10, only a falling pin edge sets the capture flag.
- R9: With edge field 11, both rising and falling pin edges set the capture flag.
- R10: No edge sets the capture flag when the edge field is 00 or when the function is not input capture.
- R11: A status write whose bits 3:0 hold any one clears the capture flag. A status write with bits 3:0 all zero leaves the flag unchanged.
- R12: An edge detected in the same cycle as a clearing status write leaves the capture flag set.
- R13: `irq` is high exactly when the capture flag is set and mode bit 8 is 1. Changing bit 8 does not alter the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 mode, 1 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read select: 0 mode, 1 status |
| rd_data | output | 32 | Combinational read data |
| pin_in | input | 1 | Asynchronous level sampled from the pad |
| pin_out | output | 1 | Level driven onto the pad |
| pin_oe | output | 1 | Pad output enable |
| irq | output | 1 | Capture interrupt request |

## Verification
Four properties are checked on every cycle:
- The output enable appears only for GPIO with a high drive bit, and never in capture mode.
- An open-drain output never drives a high level.
- The flag rises only after a detected edge and is set after any edge, which covers the clear collision.
- A clearing write with no edge drops the flag.

Other behaviour needs the bench's timed scenarios:
- the exact synchroniser latency;
- which edge polarities each edge field accepts;
- the field masking on readback;
- the interrupt gate.

// File: rtl/tpio_pkg.sv
package tpio_pkg;

    localparam int REG_W = 32;

    localparam logic [2:0] FN_OFF     = 3'd0;
    localparam logic [2:0] FN_CAPTURE = 3'd1;
    localparam logic [2:0] FN_COMPARE = 3'd2;
    localparam logic [2:0] FN_PWM     = 3'd3;
    localparam logic [2:0] FN_GPIO    = 3'd4;

    localparam logic ADDR_MODE   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    typedef struct packed {
        logic [2:0] fn;
        logic [1:0] drive;
        logic       irq_en;
        logic       od;
        logic [1:0] edg;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [REG_W-1:0] w);
        mode_t m;
        m.fn     = w[2:0];
        m.drive  = w[5:4];
        m.irq_en = w[8];
        m.od     = w[9];
        m.edg    = w[17:16];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_mode(input mode_t m);
        logic [REG_W-1:0] w;
        w        = '0;
        w[2:0]   = m.fn;
        w[5:4]   = m.drive;
        w[8]     = m.irq_en;
        w[9]     = m.od;
        w[17:16] = m.edg;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic level, input logic flag);
        logic [REG_W-1:0] w;
        w    = '0;
        w[8] = level;
        w[0] = flag;
        return w;
    endfunction

endpackage

// File: rtl/tpio_edge.sv
module tpio_edge
    import tpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  logic       capture_en,
    input  logic [1:0] edg_sel,
    output logic       level,
    output logic       edge_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   rise;
    logic                   fall;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign level = chain[LAST];

    always_comb begin
        rise       = level & ~prev;
        fall       = ~level & prev;
        edge_pulse = capture_en & ((edg_sel[0] & rise) | (edg_sel[1] & fall));
    end

endmodule

// File: rtl/tpio_regs.sv
module tpio_regs
    import tpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    input  logic             edge_pulse,
    input  logic             pin_level,
    output mode_t            mode,
    output logic             flag,
    output logic [REG_W-1:0] rd_data
);
    logic clr_req;

    assign clr_req = wr_en && (wr_addr == ADDR_STATUS) && (|wr_data[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            flag <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_MODE)
                mode <= unpack_mode(wr_data);
            flag <= edge_pulse | (flag & ~clr_req);
        end
    end

    always_comb begin
        if (rd_addr == ADDR_MODE) rd_data = pack_mode(mode);
        else                      rd_data = pack_status(pin_level, flag);
    end

    // R7: a new flag must come from a detected edge
    p_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(flag) && flag) |-> $past(edge_pulse));

    // R11: a clearing write with no edge drops the flag
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(clr_req && !edge_pulse) |-> !flag);

    // R12: an edge always leaves the flag set, even against a clear
    p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
        $past(edge_pulse) |-> flag);

endmodule

// File: rtl/tpio_pad.sv
module tpio_pad
    import tpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    output logic  pin_out,
    output logic  pin_oe
);
    logic gpio_drive;

    always_comb begin
        gpio_drive = (mode.fn == FN_GPIO) && mode.drive[1];
        pin_oe     = gpio_drive && !(mode.od && mode.drive[0]);
        pin_out    = pin_oe && !mode.od && mode.drive[0];
    end

    // R3: the output is enabled only by GPIO with a driving code
    p_oe_gpio_r3: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> (mode.fn == FN_GPIO && mode.drive[1]));

    // R4: open-drain never drives a high level
    p_od_low_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && mode.od) |-> !pin_out);

endmodule

// File: rtl/tpio_unit.sv
module tpio_unit
    import tpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq
);
    mode_t mode;
    logic  flag;
    logic  level;
    logic  edge_pulse;
    logic  capture_en;

    assign capture_en = (mode.fn == FN_CAPTURE);

    tpio_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (pin_in),
        .capture_en (capture_en),
        .edg_sel    (mode.edg),
        .level      (level),
        .edge_pulse (edge_pulse)
    );

    tpio_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .edge_pulse (edge_pulse),
        .pin_level  (level),
        .mode       (mode),
        .flag       (flag),
        .rd_data    (rd_data)
    );

    tpio_pad u_pad (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign irq = flag & mode.irq_en;

    // R5: capture mode keeps the pad an input
    p_capture_input_r5: assert property (@(posedge clk) disable iff (rst)
        (mode.fn == FN_CAPTURE) |-> !pin_oe);

endmodule

// File: tb/tpio_unit_tb_top.sv
module tpio_unit_tb_top;
    localparam int K_RD  = 0;
    localparam int K_OE  = 1;
    localparam int K_OUT = 2;
    localparam int K_IRQ = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic        irq;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #2 clk = ~clk;

    tpio_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: pops expected items at the falling edge and compares
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = rd_data;
                K_OE:    act = {31'd0, pin_oe};
                K_OUT:   act = {31'd0, pin_out};
                default: act = {31'd0, irq};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_rd(input logic a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        chk(K_RD, exp, tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk_rd(0, 32'h0, "R1 mode");
        chk_rd(1, 32'h0, "R1 status");
        chk(K_OE, 0, "R1 oe");
        chk(K_OUT, 0, "R1 out");
        chk(K_IRQ, 0, "R1 irq");

        // R2 field masking
        wr(0, 32'hFFFF_FFFF);
        chk_rd(0, 32'h0003_0337, "R2 readback");
        wr(0, 32'h0);

        // R3 GPIO drive codes
        wr(0, 32'h24); chk(K_OE, 1, "R3 low oe"); chk(K_OUT, 0, "R3 low out");
        wr(0, 32'h34); chk(K_OE, 1, "R3 high oe"); chk(K_OUT, 1, "R3 high out");
        wr(0, 32'h14); chk(K_OE, 0, "R3 input 01");
        wr(0, 32'h04); chk(K_OE, 0, "R3 input 00");

        // R4 open drain
        wr(0, 32'h234); chk(K_OE, 0, "R4 release"); chk(K_OUT, 0, "R4 release out");
        wr(0, 32'h224); chk(K_OE, 1, "R4 sink oe"); chk(K_OUT, 0, "R4 sink out");

        // R5 non-GPIO functions
        for (int f = 0; f < 8; f++) begin
            if (f != 4) begin
                wr(0, 32'h30 | f);
                chk(K_OE, 0, "R5 oe");
                chk(K_OUT, 0, "R5 out");
            end
        end

        // R10 GPIO function with edges selected: no flag, level still seen (R6)
        wr(0, 32'h3_0004);
        pin_in = 1'b1; ticks(4);
        chk_rd(1, 32'h100, "R10 gpio no flag / R6 level");
        pin_in = 1'b0; ticks(4);
        chk_rd(1, 32'h000, "R10 gpio fall no flag");
        // R10 capture with edge field 00
        wr(0, 32'h0_0001);
        pin_in = 1'b1; ticks(4);
        chk_rd(1, 32'h100, "R10 edge00 rise");
        pin_in = 1'b0; ticks(4);
        chk_rd(1, 32'h000, "R10 edge00 fall");

        // R6 / R7 rising edge timing
        wr(0, 32'h1_0001);
        pin_in = 1'b1; ticks(2);
        chk_rd(1, 32'h100, "R6 level after two edges");
        tick();
        chk_rd(1, 32'h101, "R7 rising flag after third edge");
        wr(1, 32'h1);
        chk_rd(1, 32'h100, "R11 clear");
        pin_in = 1'b0; ticks(4);
        chk_rd(1, 32'h000, "R7 falling ignored");

        // R8 falling only
        wr(0, 32'h2_0001);
        pin_in = 1'b1; ticks(4);
        chk_rd(1, 32'h100, "R8 rising ignored");
        pin_in = 1'b0; ticks(3);
        chk_rd(1, 32'h001, "R8 falling flag");
        wr(1, 32'hF);

        // R9 both edges
        wr(0, 32'h3_0001);
        pin_in = 1'b1; ticks(3);
        chk_rd(1, 32'h101, "R9 rising flag");
        wr(1, 32'h2);
        chk_rd(1, 32'h100, "R11 clear via bit1");

        // R11 zero write keeps flag
        pin_in = 1'b0; ticks(3);
        chk_rd(1, 32'h001, "R9 falling flag");
        wr(1, 32'hFFFF_FFF0);
        chk_rd(1, 32'h001, "R11 zero nibble keeps flag");
        wr(1, 32'h8);
        chk_rd(1, 32'h000, "R11 clear via bit3");

        // R12 edge collides with clear
        pin_in = 1'b1; ticks(3);
        chk_rd(1, 32'h101, "R12 setup flag");
        pin_in = 1'b0; ticks(2);
        wr(1, 32'h1);
        chk_rd(1, 32'h001, "R12 set wins");
        wr(1, 32'h1);
        chk_rd(1, 32'h000, "R12 later clear");

        // R13 interrupt gate
        pin_in = 1'b1; ticks(3);
        chk(K_IRQ, 0, "R13 gated off");
        wr(0, 32'h3_0101);
        chk(K_IRQ, 1, "R13 gated on");
        chk_rd(1, 32'h101, "R13 flag unchanged");
        wr(1, 32'h1);
        chk(K_IRQ, 0, "R13 after clear");

        tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule